// File: doc/BRIEF.md
# Load/Store Address Generator

This block works out where a load or store goes and what the base register becomes afterwards. It covers byte, halfword, word and doubleword accesses. A request carries:

- a base value, which the program counter can stand in for;
- either a 12-bit immediate or an index register, the index shifted left by a constant;
- a direction bit that picks add or subtract;
- a choice between pre-index and post-index forms;
- a writeback request.

One clock after a request, the block presents the effective address, the new base value with its write enable, and a flag for a misaligned address.

Pre-index forms address memory at base plus or minus offset and write that value back only on request. Post-index forms address memory at the unmodified base and always write the adjusted value back. A plain register-indirect access is a pre-index immediate access with a zero immediate. A misaligned address raises the fault flag and blocks writeback. All arithmetic wraps at the address width.

Top module: `ls_addr_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, rsp_valid, wb_en and align_fault are low.
- R2: Each request with req_valid high produces rsp_valid high and its results on the outputs exactly one clock later.
- R3: With use_index low, the offset is imm_off zero-extended. It is added to the base when offset_down is 0 and subtracted when offset_down is 1. A zero immediate gives plain register-indirect addressing.
- R4: With use_index high, the offset is index_val shifted left by index_shift, with bits shifted out discarded. It is added or subtracted as in R3.
- R5: With pre_index high, eff_addr equals the adjusted base (base plus or minus offset). wb_en follows wb_request.
- R6: With pre_index low (post-index), eff_addr equals the unmodified base and wb_en is high regardless of wb_request.
- R7: access_size encodes 0 byte, 1 halfword, 2 word, 3 doubleword. align_fault is raised when a halfword eff_addr has bit 0 set, or when a word or doubleword eff_addr has bits 1:0 nonzero. A byte access never faults.
- R8: When align_fault is high, wb_en is low.
- R9: When base_is_pc is high, the base used is instr_addr plus 8 and base_val is ignored.
- R10: Address and writeback arithmetic wrap modulo 2^AW in both directions.
- R11: A cycle with req_valid low yields rsp_valid, wb_en and align_fault low on the next clock.
- R12: wb_value always carries the adjusted base, in both pre-index and post-index forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| base_val | input | AW | Base register value |
| base_is_pc | input | 1 | Base is the program counter |
| instr_addr | input | AW | Address of the current instruction |
| imm_off | input | IMM_W | Unsigned immediate offset |
| index_val | input | AW | Index register value |
| use_index | input | 1 | 1 selects the shifted index, 0 the immediate |
| index_shift | input | SHW | Left shift applied to the index |
| offset_down | input | 1 | 1 subtracts the offset, 0 adds it |
| pre_index | input | 1 | 1 pre-index, 0 post-index |
| wb_request | input | 1 | Writeback wanted in pre-index form |
| access_size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| rsp_valid | output | 1 | Results valid |
| eff_addr | output | AW | Effective memory address |
| wb_value | output | AW | New base register value |
| wb_en | output | 1 | Base register write enable |
| align_fault | output | 1 | Misaligned access |

## Verification
The bench builds the block with its defaults: AW of 32, a 12-bit immediate and a 5-bit shift. With these values, the immediate reaches 0xFFF and the index shift reaches 31, where nearly all index bits are discarded. Bases near both ends of the 32-bit space show the wrap in either direction. The same widths let a post-index access have a misaligned base and still be blocked from writing back.

// File: rtl/ls_addr_gen.sv
module ls_addr_gen #(
  parameter int AW    = 32,
  parameter int IMM_W = 12,
  parameter int SHW   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    base_val,
  input  logic             base_is_pc,
  input  logic [AW-1:0]    instr_addr,
  input  logic [IMM_W-1:0] imm_off,
  input  logic [AW-1:0]    index_val,
  input  logic             use_index,
  input  logic [SHW-1:0]   index_shift,
  input  logic             offset_down,
  input  logic             pre_index,
  input  logic             wb_request,
  input  logic [1:0]       access_size,
  output logic             rsp_valid,
  output logic [AW-1:0]    eff_addr,
  output logic [AW-1:0]    wb_value,
  output logic             wb_en,
  output logic             align_fault
);

  localparam logic [AW-1:0] PC_BIAS = AW'(8);
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  logic [AW-1:0] base_eff, offset, adjusted, addr_n;
  logic          fault_n, wen_n;

  assign base_eff = base_is_pc ? instr_addr + PC_BIAS : base_val;
  assign offset   = use_index ? (index_val << index_shift) : AW'(imm_off);
  assign adjusted = offset_down ? base_eff - offset : base_eff + offset;
  assign addr_n   = pre_index ? adjusted : base_eff;

  always_comb begin
    case (access_size)
      SZ_BYTE: fault_n = 1'b0;
      SZ_HALF: fault_n = addr_n[0];
      default: fault_n = |addr_n[1:0];
    endcase
  end

  assign wen_n = (pre_index ? wb_request : 1'b1) & ~fault_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      eff_addr    <= '0;
      wb_value    <= '0;
      wb_en       <= 1'b0;
      align_fault <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      eff_addr    <= addr_n;
      wb_value    <= adjusted;
      wb_en       <= req_valid & wen_n;
      align_fault <= req_valid & fault_n;
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !wb_en && !align_fault); // R11
  AST_FAULT_BLOCKS_WB: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> !wb_en); // R8
  AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !pre_index && !base_is_pc |=> eff_addr == $past(base_val)); // R6
  AST_BYTE_NOFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && access_size == SZ_BYTE |=> !align_fault); // R7
  AST_PRE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && pre_index && !wb_request |=> !wb_en); // R5

endmodule

// File: tb/ls_addr_gen_test.sv
`timescale 1ns/1ps
module ls_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] base_val = '0;
  logic        base_is_pc = 1'b0;
  logic [31:0] instr_addr = '0;
  logic [11:0] imm_off = '0;
  logic [31:0] index_val = '0;
  logic        use_index = 1'b0;
  logic [4:0]  index_shift = '0;
  logic        offset_down = 1'b0;
  logic        pre_index = 1'b0;
  logic        wb_request = 1'b0;
  logic [1:0]  access_size = '0;
  logic        rsp_valid, wb_en, align_fault;
  logic [31:0] eff_addr, wb_value;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ls_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_val(base_val),
    .base_is_pc(base_is_pc), .instr_addr(instr_addr), .imm_off(imm_off),
    .index_val(index_val), .use_index(use_index), .index_shift(index_shift),
    .offset_down(offset_down), .pre_index(pre_index), .wb_request(wb_request),
    .access_size(access_size), .rsp_valid(rsp_valid), .eff_addr(eff_addr),
    .wb_value(wb_value), .wb_en(wb_en), .align_fault(align_fault)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input string req,
      input logic [31:0] b, input logic pcb, input logic [31:0] ia,
      input logic [11:0] imm, input logic [31:0] idx, input logic ui,
      input logic [4:0] sh, input logic dn, input logic pre,
      input logic wr, input logic [1:0] sz);
    logic [31:0] be, off, adj, ad;
    logic flt, we;
    be  = pcb ? ia + 32'd8 : b;
    off = ui ? (idx << sh) : {20'd0, imm};
    adj = dn ? be - off : be + off;
    ad  = pre ? adj : be;
    flt = (sz == 2'd1) ? ad[0] : (sz == 2'd0) ? 1'b0 : (ad[1:0] != 2'b00);
    we  = (pre ? wr : 1'b1) && !flt;
    @(negedge clk);
    req_valid = 1'b1; base_val = b; base_is_pc = pcb; instr_addr = ia;
    imm_off = imm; index_val = idx; use_index = ui; index_shift = sh;
    offset_down = dn; pre_index = pre; wb_request = wr; access_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    check(req, "eff_addr", eff_addr, ad);
    check(req, "wb_value", wb_value, adj);
    check(req, "wb_en", {31'd0, wb_en}, {31'd0, we});
    check(req, "align_fault", {31'd0, align_fault}, {31'd0, flt});
  endtask

  task automatic t_reset;
    check("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1", "wb_en", {31'd0, wb_en}, 32'd0);
    check("R1", "align_fault", {31'd0, align_fault}, 32'd0);
  endtask

  task automatic t_immediate;
    run_case("R3", 32'h1000, 0, 0, 12'h000, 0, 0, 0, 0, 1, 1, 2'd2);
    check("R3", "indirect addr", eff_addr, 32'h1000);
    run_case("R3", 32'h1000, 0, 0, 12'hFFC, 0, 0, 0, 0, 1, 0, 2'd2);
    check("R3", "imm add", eff_addr, 32'h1FFC);
    run_case("R3", 32'h1000, 0, 0, 12'h010, 0, 0, 0, 1, 1, 1, 2'd3);
    check("R3", "imm sub", eff_addr, 32'h0FF0);
  endtask

  task automatic t_index;
    run_case("R4", 32'h2000, 0, 0, 12'h0, 32'h3, 1, 5'd4, 0, 1, 1, 2'd2);
    check("R4", "shifted add", eff_addr, 32'h2030);
    run_case("R4", 32'h2000, 0, 0, 12'h0, 32'h3, 1, 5'd2, 1, 1, 0, 2'd2);
    check("R4", "shifted sub", eff_addr, 32'h1FF4);
    run_case("R4", 32'h0, 0, 0, 12'h0, 32'h3, 1, 5'd31, 0, 1, 0, 2'd0);
    check("R4", "shift 31", eff_addr, 32'h8000_0000);
  endtask

  task automatic t_pre_post;
    run_case("R5", 32'h400, 0, 0, 12'h8, 0, 0, 0, 0, 1, 0, 2'd2);
    check("R5", "no wb without request", {31'd0, wb_en}, 32'd0);
    run_case("R6", 32'h400, 0, 0, 12'h8, 0, 0, 0, 0, 0, 0, 2'd2);
    check("R6", "post addr", eff_addr, 32'h400);
    check("R6", "post wb forced", {31'd0, wb_en}, 32'd1);
    check("R12", "post wb value", wb_value, 32'h408);
    run_case("R12", 32'h400, 0, 0, 12'h0, 32'h5, 1, 5'd1, 1, 0, 1, 2'd0);
    check("R12", "post wb sub value", wb_value, 32'h3F6);
  endtask

  task automatic t_align;
    run_case("R7", 32'h101, 0, 0, 12'h0, 0, 0, 0, 0, 1, 1, 2'd0);
    check("R7", "byte odd ok", {31'd0, align_fault}, 32'd0);
    run_case("R7", 32'h100, 0, 0, 12'h1, 0, 0, 0, 0, 1, 1, 2'd1);
    check("R7", "half odd", {31'd0, align_fault}, 32'd1);
    run_case("R7", 32'h100, 0, 0, 12'h2, 0, 0, 0, 0, 1, 1, 2'd1);
    check("R7", "half even", {31'd0, align_fault}, 32'd0);
    run_case("R7", 32'h100, 0, 0, 12'h2, 0, 0, 0, 0, 1, 1, 2'd2);
    check("R7", "word bit1", {31'd0, align_fault}, 32'd1);
    run_case("R8", 32'h102, 0, 0, 12'h2, 0, 0, 0, 0, 0, 0, 2'd3);
    check("R8", "post fault blocks wb", {31'd0, wb_en}, 32'd0);
    check("R8", "post fault raised", {31'd0, align_fault}, 32'd1);
  endtask

  task automatic t_pc_wrap;
    run_case("R9", 32'hDEAD_BEEF, 1, 32'h8000, 12'h4, 0, 0, 0, 0, 1, 0, 2'd2);
    check("R9", "pc base", eff_addr, 32'h800C);
    run_case("R10", 32'hFFFF_FFF0, 0, 0, 12'h20, 0, 0, 0, 0, 1, 1, 2'd2);
    check("R10", "wrap up", eff_addr, 32'h10);
    run_case("R10", 32'h4, 0, 0, 12'h8, 0, 0, 0, 1, 0, 1, 2'd2);
    check("R10", "wrap down", wb_value, 32'hFFFF_FFFC);
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R11", "rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
    check("R11", "wb_en idle", {31'd0, wb_en}, 32'd0);
    check("R11", "fault idle", {31'd0, align_fault}, 32'd0);
    run_case("R2", 32'h3000, 0, 0, 12'h4, 0, 0, 0, 0, 1, 1, 2'd2);
    @(negedge clk);
    check("R2", "single-cycle valid", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_index();
    t_pre_post();
    t_align();
    t_pc_wrap();
    t_idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule